// File: doc/BRIEF.md
# Interrupt Controller Host Register Decoder

This block is the host-facing side of one eight-line interrupt controller. The host sees two byte-wide locations chosen by one address bit. Writes to location 0 are sorted into three kinds by bits 4 and 3: an initialisation opener, a mode command, or an end-of-service/rotation command. Writes to location 1 either continue the initialisation sequence or, once that sequence is over, load the line mask. The sequence is two or three words long after the opener; the opener decides which.

The block holds the decoded configuration: vector base, automatic end-of-service, nested mode for cascaded requests, mask, read-select and special mask. It also produces one-cycle strobes for reinitialisation, for the end-of-service/rotation opcode and for the line cleared by a poll read. A separate priority resolver consumes these outputs. That resolver supplies the current request and in-service vectors, plus the winning line and a flag saying whether any line wins. Reads are combinational in the default build. Side effects of a read take place at the clock edge that ends the read cycle.

Top module: `intc_cmd_decoder`

## Requirements
- R1: After reset the init phase is 0. Mask, vector base, nested mode, automatic end-of-service, read-select, special mask and poll are all 0, and no strobe is high. A reset in the middle of an init sequence returns the phase to 0.
- R2: A write to location 0 with bit 4 set opens initialisation. In the next cycle reinit_pulse is high for exactly one cycle and init_phase is 1. The same write clears mask, read-select and special mask.
- R3: The opener's bit 0 records whether a third word follows. When that bit is 0 the opener also clears nested mode and automatic end-of-service. When it is 1, both keep their values.
- R4: In phase 1, a write to location 1 sets vec_base to the data with bits 2:0 forced to 0, and the phase becomes 2.
- R5: In phase 2, a write to location 1 moves the phase to 3 if the opener's bit 0 was 1, and to 0 otherwise.
- R6: In phase 3, a write to location 1 sets nested mode from bit 4 and automatic end-of-service from bit 1, and the phase becomes 0.
- R7: In phase 0, a write to location 1 loads the mask from the data.
- R8: A write to location 0 with bit 4 clear and bit 3 set is a mode command. If bit 1 is set, bit 0 loads read-select (1 selects in-service, 0 selects request). If bit 6 is set, bit 5 loads special mask. Fields whose enable bit is clear keep their values.
- R9: A mode command with bit 2 set arms poll. A mode command with bit 2 clear leaves poll as it was.
- R10: A write to location 0 with bits 4 and 3 clear raises cmd_pulse for exactly one cycle. The opcode (data bits 7:5) appears on cmd_op and the line (bits 2:0) on cmd_line, and both hold until the next such command.
- R11: A read with poll not armed returns the in-service vector from location 0 when read-select is 1, and the request vector when it is 0. Location 1 returns the mask.
- R12: A read with poll armed and a line resolved returns that line number at either location. In the next cycle clr_pulse is high for one cycle with that line on clr_line, and poll is disarmed.
- R13: A read with poll armed and no line resolved returns 7, raises no clr_pulse, and disarms poll.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 1 | Location select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high; 0 otherwise |
| irr_in | input | 8 | Request vector from the request latch |
| isr_in | input | 8 | In-service vector from the resolver |
| res_line | input | 3 | Line the resolver would grant |
| res_valid | input | 1 | A line is resolved |
| init_phase | output | 2 | Init sequence phase (0 = running) |
| vec_base | output | 8 | Vector base, low three bits 0 |
| nest_mode | output | 1 | Nested mode for cascaded requests |
| auto_eoi | output | 1 | Automatic end-of-service |
| reinit_pulse | output | 1 | Reinitialise strobe |
| mask_q | output | 8 | Line mask |
| read_isr | output | 1 | Read-select (1 = in-service) |
| spec_mask | output | 1 | Special mask mode |
| poll_armed | output | 1 | Poll armed for the next read |
| cmd_pulse | output | 1 | End-of-service/rotation command strobe |
| cmd_op | output | 3 | Command opcode |
| cmd_line | output | 3 | Command line field |
| clr_pulse | output | 1 | Poll read cleared a line |
| clr_line | output | 3 | Line cleared by the poll read |

## Verification
The bench targets the two-way split of the init sequence. A design that ignored the opener's bit 0 would either stall in phase 3 and swallow the next mask write, or skip the third word and never load nested mode and automatic end-of-service. It also checks that a short reinit clears those two fields while a long one keeps them, and that a mode command with its enable bits clear changes nothing. For poll reads, it covers the empty case that must return 7 without a clear strobe, and it confirms poll is disarmed in both cases. A design that left poll armed would misreport the next status read.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
   // bit positions the command and init decoding depend on
   localparam int unsigned B_INIT   = 4;
   localparam int unsigned B_MODE   = 3;
   localparam int unsigned B_POLL   = 2;
   localparam int unsigned B_SELEN  = 1;
   localparam int unsigned B_SELVAL = 0;
   localparam int unsigned B_SMEN   = 6;
   localparam int unsigned B_SMVAL  = 5;
   localparam int unsigned B_NEED3  = 0;
   localparam int unsigned B_NEST   = 4;
   localparam int unsigned B_AEOI   = 1;
   localparam int unsigned OP_LSB   = 5;
   localparam int unsigned OP_W     = 3;

   typedef enum logic [1:0] {
      PH_RUN  = 2'd0,
      PH_BASE = 2'd1,
      PH_CASC = 2'd2,
      PH_MODE = 2'd3
   } phase_e;

   typedef struct packed {
      logic poll;
      logic sel_en;
      logic sel_val;
      logic sm_en;
      logic sm_val;
   } mode_fields_t;
endpackage

// File: rtl/intc_wr_class.sv
`timescale 1ns/1ps
module intc_wr_class
   import intc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LINE_W = 3
) (
   input  logic              wr_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              is_init,
   output logic              is_mode,
   output logic              is_cmd,
   output logic              p1_wr,
   output mode_fields_t      mode_f,
   output logic [OP_W-1:0]   op_f,
   output logic [LINE_W-1:0] line_f
);
   logic p0_wr;

   assign p0_wr   = wr_en && !addr;
   assign p1_wr   = wr_en && addr;
   assign is_init = p0_wr && wdata[B_INIT];
   assign is_mode = p0_wr && !wdata[B_INIT] && wdata[B_MODE];
   assign is_cmd  = p0_wr && !wdata[B_INIT] && !wdata[B_MODE];

   always_comb begin
      mode_f.poll    = wdata[B_POLL];
      mode_f.sel_en  = wdata[B_SELEN];
      mode_f.sel_val = wdata[B_SELVAL];
      mode_f.sm_en   = wdata[B_SMEN];
      mode_f.sm_val  = wdata[B_SMVAL];
   end

   assign op_f   = wdata[OP_LSB +: OP_W];
   assign line_f = wdata[LINE_W-1:0];
endmodule

// File: rtl/intc_init_seq.sv
`timescale 1ns/1ps
module intc_init_seq
   import intc_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LINE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_init,
   input  logic              p1_wr,
   input  logic [DATA_W-1:0] wdata,
   output phase_e            phase,
   output logic [DATA_W-1:0] vec_base,
   output logic              nest_mode,
   output logic              auto_eoi,
   output logic              reinit_pulse,
   output logic              mask_wr
);
   localparam logic [DATA_W-1:0] BASE_MASK = ~((DATA_W)'((1 << LINE_W) - 1));

   logic need3;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase        <= PH_RUN;
         need3        <= 1'b0;
         vec_base     <= '0;
         nest_mode    <= 1'b0;
         auto_eoi     <= 1'b0;
         reinit_pulse <= 1'b0;
      end else begin
         reinit_pulse <= is_init;
         if (is_init) begin
            need3 <= wdata[B_NEED3];
            phase <= PH_BASE;
            if (!wdata[B_NEED3]) begin
               nest_mode <= 1'b0;
               auto_eoi  <= 1'b0;
            end
         end else if (p1_wr) begin
            case (phase)
               PH_BASE: begin
                  vec_base <= wdata & BASE_MASK;
                  phase    <= PH_CASC;
               end
               PH_CASC: phase <= need3 ? PH_MODE : PH_RUN;
               PH_MODE: begin
                  nest_mode <= wdata[B_NEST];
                  auto_eoi  <= wdata[B_AEOI];
                  phase     <= PH_RUN;
               end
               default: ;
            endcase
         end
      end
   end

   assign mask_wr = p1_wr && (phase == PH_RUN);
endmodule

// File: rtl/intc_ctl_regs.sv
`timescale 1ns/1ps
module intc_ctl_regs
   import intc_pkg::*;
#(
   parameter int unsigned LINES  = 8,
   parameter int unsigned LINE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              is_init,
   input  logic              is_mode,
   input  logic              is_cmd,
   input  logic              mask_wr,
   input  logic [LINES-1:0]  mask_data,
   input  mode_fields_t      mode_f,
   input  logic [OP_W-1:0]   op_f,
   input  logic [LINE_W-1:0] line_f,
   input  logic              rd_take,
   input  logic              res_valid,
   input  logic [LINE_W-1:0] res_line,
   output logic [LINES-1:0]  mask_q,
   output logic              read_isr,
   output logic              spec_mask,
   output logic              poll_armed,
   output logic              cmd_pulse,
   output logic [OP_W-1:0]   cmd_op,
   output logic [LINE_W-1:0] cmd_line,
   output logic              clr_pulse,
   output logic [LINE_W-1:0] clr_line
);
   logic poll_take;

   assign poll_take = rd_take && poll_armed;

   // mask, select and special-mask state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q    <= '0;
         read_isr  <= 1'b0;
         spec_mask <= 1'b0;
      end else begin
         if (is_init) begin
            mask_q    <= '0;
            read_isr  <= 1'b0;
            spec_mask <= 1'b0;
         end else begin
            if (mask_wr) mask_q <= mask_data;
            if (is_mode && mode_f.sel_en) read_isr  <= mode_f.sel_val;
            if (is_mode && mode_f.sm_en)  spec_mask <= mode_f.sm_val;
         end
      end
   end

   // poll arming and the clear strobe it yields
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         poll_armed <= 1'b0;
         clr_pulse  <= 1'b0;
         clr_line   <= '0;
      end else begin
         clr_pulse <= 1'b0;
         if (is_mode && mode_f.poll) begin
            poll_armed <= 1'b1;
         end else if (poll_take) begin
            poll_armed <= 1'b0;
            if (res_valid) begin
               clr_pulse <= 1'b1;
               clr_line  <= res_line;
            end
         end
      end
   end

   // end-of-service / rotation command strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_pulse <= 1'b0;
         cmd_op    <= '0;
         cmd_line  <= '0;
      end else begin
         cmd_pulse <= is_cmd;
         if (is_cmd) begin
            cmd_op   <= op_f;
            cmd_line <= line_f;
         end
      end
   end
endmodule

// File: rtl/intc_read_path.sv
`timescale 1ns/1ps
module intc_read_path #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned LINES     = 8,
   parameter int unsigned LINE_W    = 3,
   parameter bit          READ_PIPE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              addr,
   input  logic              poll_armed,
   input  logic              read_isr,
   input  logic [LINES-1:0]  irr_in,
   input  logic [LINES-1:0]  isr_in,
   input  logic [LINES-1:0]  mask_q,
   input  logic              res_valid,
   input  logic [LINE_W-1:0] res_line,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [DATA_W-1:0] SPUR_CODE = (DATA_W)'(LINES - 1);

   logic [DATA_W-1:0] rd_val;

   always_comb begin
      if (poll_armed)
         rd_val = res_valid ? (DATA_W)'(res_line) : SPUR_CODE;
      else if (addr)
         rd_val = (DATA_W)'(mask_q);
      else if (read_isr)
         rd_val = (DATA_W)'(isr_in);
      else
         rd_val = (DATA_W)'(irr_in);
   end

   if (READ_PIPE) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rdata <= '0;
         else        rdata <= rd_en ? rd_val : '0;
      end
   end else begin : g_rd_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata = rd_en ? rd_val : '0;
   end
endmodule

// File: rtl/intc_cmd_decoder.sv
`timescale 1ns/1ps
module intc_cmd_decoder
   import intc_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned LINES     = 8,
   parameter bit          READ_PIPE = 1'b0,
   localparam int unsigned LINE_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [LINES-1:0]  irr_in,
   input  logic [LINES-1:0]  isr_in,
   input  logic [LINE_W-1:0] res_line,
   input  logic              res_valid,
   output logic [1:0]        init_phase,
   output logic [DATA_W-1:0] vec_base,
   output logic              nest_mode,
   output logic              auto_eoi,
   output logic              reinit_pulse,
   output logic [LINES-1:0]  mask_q,
   output logic              read_isr,
   output logic              spec_mask,
   output logic              poll_armed,
   output logic              cmd_pulse,
   output logic [OP_W-1:0]   cmd_op,
   output logic [LINE_W-1:0] cmd_line,
   output logic              clr_pulse,
   output logic [LINE_W-1:0] clr_line
);
   if (DATA_W < 8) begin : g_bad_data_w
      $error("DATA_W must be at least 8 to hold the command fields");
   end
   if (LINES < 2 || LINES > 8 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two from 2 to 8");
   end
   if (LINES > DATA_W) begin : g_bad_fit
      $error("LINES must not exceed DATA_W");
   end

   logic         is_init, is_mode, is_cmd, p1_wr, mask_wr, rd_take;
   mode_fields_t mode_f;
   logic [OP_W-1:0]   op_f;
   logic [LINE_W-1:0] line_f;
   phase_e       phase;

   intc_wr_class #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_class (
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .is_init (is_init),
      .is_mode (is_mode),
      .is_cmd  (is_cmd),
      .p1_wr   (p1_wr),
      .mode_f  (mode_f),
      .op_f    (op_f),
      .line_f  (line_f)
   );

   intc_init_seq #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_init (
      .clk          (clk),
      .rst_n        (rst_n),
      .is_init      (is_init),
      .p1_wr        (p1_wr),
      .wdata        (wdata),
      .phase        (phase),
      .vec_base     (vec_base),
      .nest_mode    (nest_mode),
      .auto_eoi     (auto_eoi),
      .reinit_pulse (reinit_pulse),
      .mask_wr      (mask_wr)
   );

   assign rd_take = rd_en && !wr_en;

   intc_ctl_regs #(.LINES(LINES), .LINE_W(LINE_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .is_init    (is_init),
      .is_mode    (is_mode),
      .is_cmd     (is_cmd),
      .mask_wr    (mask_wr),
      .mask_data  (wdata[LINES-1:0]),
      .mode_f     (mode_f),
      .op_f       (op_f),
      .line_f     (line_f),
      .rd_take    (rd_take),
      .res_valid  (res_valid),
      .res_line   (res_line),
      .mask_q     (mask_q),
      .read_isr   (read_isr),
      .spec_mask  (spec_mask),
      .poll_armed (poll_armed),
      .cmd_pulse  (cmd_pulse),
      .cmd_op     (cmd_op),
      .cmd_line   (cmd_line),
      .clr_pulse  (clr_pulse),
      .clr_line   (clr_line)
   );

   intc_read_path #(
      .DATA_W(DATA_W), .LINES(LINES), .LINE_W(LINE_W), .READ_PIPE(READ_PIPE)
   ) u_rd (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_en      (rd_en),
      .addr       (addr),
      .poll_armed (poll_armed),
      .read_isr   (read_isr),
      .irr_in     (irr_in),
      .isr_in     (isr_in),
      .mask_q     (mask_q),
      .res_valid  (res_valid),
      .res_line   (res_line),
      .rdata      (rdata)
   );

   assign init_phase = phase;
endmodule

// File: rtl/intc_cmd_decoder_chk.sv
`timescale 1ns/1ps
module intc_cmd_decoder_chk #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned LINES  = 8,
   parameter int unsigned LINE_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic              addr,
   input logic [DATA_W-1:0] wdata,
   input logic              res_valid,
   input logic [1:0]        init_phase,
   input logic [DATA_W-1:0] vec_base,
   input logic              nest_mode,
   input logic              auto_eoi,
   input logic              reinit_pulse,
   input logic [LINES-1:0]  mask_q,
   input logic              read_isr,
   input logic              spec_mask,
   input logic              poll_armed,
   input logic              cmd_pulse,
   input logic [2:0]        cmd_op,
   input logic              clr_pulse
);
   localparam logic [DATA_W-1:0] BASE_MASK = ~((DATA_W)'((1 << LINE_W) - 1));

   logic opener, p0_cmd, p1_w;
   assign opener = wr_en && !addr && wdata[4];
   assign p0_cmd = wr_en && !addr && !wdata[4] && !wdata[3];
   assign p1_w   = wr_en && addr;

   p_init_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
      opener |=> (reinit_pulse && init_phase == 2'd1 && mask_q == '0 && !read_isr && !spec_mask));

   p_keep_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (opener && wdata[0]) |=> ($stable(nest_mode) && $stable(auto_eoi)));

   p_clear_cfg_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (opener && !wdata[0]) |=> (!nest_mode && !auto_eoi));

   p_base_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (p1_w && init_phase == 2'd1) |=> (vec_base == ($past(wdata) & BASE_MASK) && init_phase == 2'd2));

   p_casc_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (p1_w && init_phase == 2'd2) |=> (init_phase == 2'd3 || init_phase == 2'd0));

   p_mode_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (p1_w && init_phase == 2'd3) |=> (init_phase == 2'd0 && nest_mode == $past(wdata[4]) && auto_eoi == $past(wdata[1])));

   p_mask_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (p1_w && init_phase == 2'd0) |=> (mask_q == $past(wdata[LINES-1:0])));

   p_cmd_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      p0_cmd |=> (cmd_pulse && cmd_op == $past(wdata[7:5])));

   p_cmd_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !p0_cmd |=> !cmd_pulse);

   p_poll_disarm_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && poll_armed) |=> !poll_armed);

   p_clr_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |-> $past(rd_en && !wr_en && poll_armed && res_valid));

   p_empty_poll_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && poll_armed && !res_valid) |=> !clr_pulse);
endmodule

bind intc_cmd_decoder intc_cmd_decoder_chk #(
   .DATA_W(DATA_W), .LINES(LINES), .LINE_W(LINE_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .rd_en        (rd_en),
   .addr         (addr),
   .wdata        (wdata),
   .res_valid    (res_valid),
   .init_phase   (init_phase),
   .vec_base     (vec_base),
   .nest_mode    (nest_mode),
   .auto_eoi     (auto_eoi),
   .reinit_pulse (reinit_pulse),
   .mask_q       (mask_q),
   .read_isr     (read_isr),
   .spec_mask    (spec_mask),
   .poll_armed   (poll_armed),
   .cmd_pulse    (cmd_pulse),
   .cmd_op       (cmd_op),
   .clr_pulse    (clr_pulse)
);

// File: tb/tb_intc_cmd_decoder.sv
`timescale 1ns/1ps
module tb_intc_cmd_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic [7:0] irr_in = 8'hA5, isr_in = 8'h3C;
   logic [2:0] res_line = 3'd5;
   logic       res_valid = 1'b1;
   logic [1:0] init_phase;
   logic [7:0] vec_base, mask_q;
   logic       nest_mode, auto_eoi, reinit_pulse, read_isr, spec_mask, poll_armed;
   logic       cmd_pulse, clr_pulse;
   logic [2:0] cmd_op, cmd_line, clr_line;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   intc_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .isr_in(isr_in),
      .res_line(res_line), .res_valid(res_valid), .init_phase(init_phase),
      .vec_base(vec_base), .nest_mode(nest_mode), .auto_eoi(auto_eoi),
      .reinit_pulse(reinit_pulse), .mask_q(mask_q), .read_isr(read_isr),
      .spec_mask(spec_mask), .poll_armed(poll_armed), .cmd_pulse(cmd_pulse),
      .cmd_op(cmd_op), .cmd_line(cmd_line), .clr_pulse(clr_pulse), .clr_line(clr_line)
   );

   // observed quantity selected by a vector's kind field
   function automatic logic [7:0] obs(input logic [2:0] k);
      case (k)
         3'd0: obs = {6'd0, init_phase};
         3'd1: obs = mask_q;
         3'd2: obs = vec_base;
         3'd3: obs = {6'd0, nest_mode, auto_eoi};
         3'd4: obs = rdata;
         3'd5: obs = {5'd0, read_isr, spec_mask, poll_armed};
         3'd6: obs = {1'b0, cmd_pulse, cmd_op, cmd_line};
         default: obs = {4'd0, clr_pulse, clr_line};
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   task automatic do_wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // returns read data sampled mid-cycle; side effects visible on return
   task automatic do_rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // {op[1:0] 0=idle 1=write 2=read, addr, wdata[7:0], kind[2:0], exp[7:0], req[3:0]}
   localparam int NV = 29;
   localparam logic [25:0] TBL [NV] = '{
      {2'd1,1'b0,8'h11,3'd0,8'h01,4'd2 },  // R2 opener, third word wanted
      {2'd1,1'b1,8'h47,3'd2,8'h40,4'd4 },  // R4 base low bits dropped
      {2'd1,1'b1,8'h00,3'd0,8'h03,4'd5 },  // R5 to phase 3
      {2'd1,1'b1,8'h12,3'd3,8'h03,4'd6 },  // R6 nested and auto set
      {2'd1,1'b1,8'h5A,3'd1,8'h5A,4'd7 },  // R7 mask load
      {2'd2,1'b1,8'h00,3'd4,8'h5A,4'd11},  // R11 mask read
      {2'd2,1'b0,8'h00,3'd4,8'hA5,4'd11},  // R11 request read
      {2'd1,1'b0,8'h0B,3'd5,8'h04,4'd8 },  // R8 select in-service
      {2'd2,1'b0,8'h00,3'd4,8'h3C,4'd11},  // R11 in-service read
      {2'd1,1'b0,8'h68,3'd5,8'h06,4'd8 },  // R8 special mask on
      {2'd1,1'b0,8'h08,3'd5,8'h06,4'd8 },  // R8 no enables: unchanged
      {2'd1,1'b0,8'h13,3'd3,8'h03,4'd3 },  // R3 long opener keeps config
      {2'd0,1'b0,8'h00,3'd1,8'h00,4'd2 },  // R2 mask cleared
      {2'd1,1'b1,8'h40,3'd0,8'h02,4'd4 },  // R4 phase 2
      {2'd1,1'b1,8'h00,3'd0,8'h03,4'd5 },  // R5 to phase 3
      {2'd1,1'b1,8'h10,3'd3,8'h02,4'd6 },  // R6 nested only
      {2'd1,1'b0,8'h10,3'd0,8'h01,4'd2 },  // R2 short opener
      {2'd0,1'b0,8'h00,3'd3,8'h00,4'd3 },  // R3 config cleared
      {2'd1,1'b1,8'h88,3'd2,8'h88,4'd4 },  // R4 base
      {2'd1,1'b1,8'hFF,3'd0,8'h00,4'd5 },  // R5 skip third word
      {2'd1,1'b1,8'hC3,3'd1,8'hC3,4'd7 },  // R7 mask load
      {2'd1,1'b0,8'hE3,3'd6,8'h7B,4'd10},  // R10 op 7 line 3
      {2'd1,1'b0,8'h25,3'd6,8'h4D,4'd10},  // R10 op 1 line 5
      {2'd0,1'b0,8'h00,3'd6,8'h0D,4'd10},  // R10 strobe one cycle
      {2'd1,1'b0,8'h0C,3'd5,8'h01,4'd9 },  // R9 poll armed
      {2'd2,1'b0,8'h00,3'd4,8'h05,4'd12},  // R12 poll returns line
      {2'd0,1'b0,8'h00,3'd5,8'h00,4'd12},  // R12 poll disarmed
      {2'd2,1'b0,8'h00,3'd4,8'hA5,4'd11},  // R11 select cleared by reinit
      {2'd1,1'b1,8'hF0,3'd1,8'hF0,4'd7 }   // R7 mask load
   };

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1", "phase", obs(3'd0), 8'h00);
      chk("R1", "mask", obs(3'd1), 8'h00);
      chk("R1", "base", obs(3'd2), 8'h00);
      chk("R1", "config", obs(3'd3), 8'h00);
      chk("R1", "flags", obs(3'd5), 8'h00);
      chk("R1", "strobes", {reinit_pulse, cmd_pulse, clr_pulse}, 8'h00);
      do_rd(1'b0, d);
      chk("R1", "read selects request", d, 8'hA5);

      for (int i = 0; i < NV; i++) begin
         automatic logic [25:0] v = TBL[i];
         automatic logic [7:0] got;
         got = 8'h00;
         case (v[25:24])
            2'd1: begin do_wr(v[23], v[22:15]); got = obs(v[14:12]); end
            2'd2: begin do_rd(v[23], got); if (v[14:12] != 3'd4) got = obs(v[14:12]); end
            default: begin @(negedge clk); got = obs(v[14:12]); end
         endcase
         n_chk++;
         if (got !== v[11:4]) begin
            n_bad++;
            $display("FAIL R%0d vector %0d: actual %02h expected %02h", v[3:0], i, got, v[11:4]);
         end
      end

      // R2 reinit strobe lasts one cycle
      do_wr(1'b0, 8'h10);
      chk("R2", "reinit high", {7'd0, reinit_pulse}, 8'h01);
      @(negedge clk);
      chk("R2", "reinit low", {7'd0, reinit_pulse}, 8'h00);
      do_wr(1'b1, 8'h20);
      do_wr(1'b1, 8'h00);
      chk("R5", "back to running", obs(3'd0), 8'h00);

      // R12 poll clear strobe carries the line
      res_line = 3'd3; res_valid = 1'b1;
      do_wr(1'b0, 8'h0C);
      do_rd(1'b1, d);
      chk("R12", "poll data at location 1", d, 8'h03);
      chk("R12", "clear strobe", obs(3'd7), 8'h0B);
      chk("R12", "poll disarmed", {7'd0, poll_armed}, 8'h00);
      @(negedge clk);
      chk("R12", "clear strobe drops", {7'd0, clr_pulse}, 8'h00);

      // R13 empty poll
      res_valid = 1'b0;
      do_wr(1'b0, 8'h0C);
      do_rd(1'b0, d);
      chk("R13", "empty poll code", d, 8'h07);
      chk("R13", "no clear strobe", {7'd0, clr_pulse}, 8'h00);
      chk("R13", "poll disarmed", {7'd0, poll_armed}, 8'h00);
      do_rd(1'b0, d);
      chk("R13", "next read is status", d, 8'hA5);

      // R9 mode write without poll bit leaves poll alone
      do_wr(1'b0, 8'h0C);
      do_wr(1'b0, 8'h0A);
      chk("R9", "poll kept", {7'd0, poll_armed}, 8'h01);
      do_rd(1'b0, d);
      res_valid = 1'b1;

      // R1 reset in mid-sequence
      do_wr(1'b0, 8'h11);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "phase after mid reset", obs(3'd0), 8'h00);
      do_wr(1'b1, 8'h77);
      chk("R1", "location 1 is mask after reset", obs(3'd1), 8'h77);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule